// File: doc/BRIEF.md
# BCD Calendar Counter with Coherent Snapshot

This block holds a wall-clock calendar of seven packed-BCD bytes: seconds, minutes, hours (24-hour form), day of month, month, two-digit year and weekday. Each pulse on the one-second tick input moves the calendar forward by one second, but only while the run bit in the control byte is set. Every carry ripples through to the higher fields on the same tick. Month lengths are computed from the month and the year, and February has 29 days in years divisible by four.

Host software uses a byte-wide register port. It halts the counter, writes the seven time bytes, and then sets the run bit again. To read the time safely while the counter runs, software first requests a snapshot. The block then copies all live fields into a shadow set in a single cycle, and the time offsets return those frozen values until a control write clears the request. Four one-cycle pulses report each advance and each minute, hour and day rollover to neighbouring logic.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control byte reads 0x00, so the counter is halted. All four event outputs are low.
- R2: Offsets 0..6 hold seconds, minutes, hours, day, month, year and weekday in packed BCD. A tick advances seconds by one BCD step only when control bit 0 (run) is 1. A tick seen while run is 0 changes nothing.
- R3: Seconds and minutes wrap from 0x59 to 0x00, and hours wrap from 0x23 to 0x00. Each wrap increments the next field within the same tick.
- R4: On the hour wrap, the day advances. When the day passes the month's last day (30 for months 04, 06, 09 and 11, and 31 for the other months except February), it returns to 0x01 and the month increments. The month wraps from 0x12 to 0x01 and carries into the year, and the year wraps from 0x99 to 0x00.
- R5: February ends on day 0x29 when the two-digit year is divisible by four, and on day 0x28 otherwise.
- R6: The weekday advances on every hour wrap (day change) and wraps from 0x06 to 0x00.
- R7: Writing control offset 0x8 with bit 6 set raises bit 6 for exactly one cycle. At the next edge the live fields are copied into the shadow set and bit 7 (shadow view) is set. While bit 7 is 1, reads of offsets 0..6 return the shadow values. A control write with bit 6 clear also clears bit 7.
- R8: A time-field write in the same cycle as an enabled tick is stored, and that tick is dropped: no field advances and no event pulses.
- R9: The events are registered and last one cycle, arriving together with the new time. evt_sec marks each advance, evt_min a seconds wrap, evt_hour a minutes wrap and evt_day an hours wrap.
- R10: A write to offsets 0..6 stores the byte verbatim and reads back unchanged. Control bits 1 through 5 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte for reg_addr |
| evt_sec | output | 1 | Advance pulse |
| evt_min | output | 1 | Minute rollover pulse |
| evt_hour | output | 1 | Hour rollover pulse |
| evt_day | output | 1 | Day rollover pulse |

## Verification
A tick or write applied before an edge shows up in the state, the events and rd_data straight after that edge. The bench therefore drives each stimulus at a falling edge, samples the events at the next falling edge, and checks one cycle later that they have dropped. A snapshot request spans two edges: bit 6 is visible after the first and the shadow view after the second, so the control byte is read at each of those falling edges in turn. rd_data is combinational, so each read sets the address and samples 1 ns later, and only while no tick or write is pending.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
    localparam int FIELDS  = 7;
    localparam int IX_SEC  = 0;
    localparam int IX_MIN  = 1;
    localparam int IX_HOUR = 2;
    localparam int IX_DAY  = 3;
    localparam int IX_MON  = 4;
    localparam int IX_YEAR = 5;
    localparam int IX_WDAY = 6;
    localparam int EVTS    = 4;

    typedef logic [7:0] bcd8_t;
    typedef logic [FIELDS-1:0][7:0] cal_fields_t;

    typedef struct packed {
        cal_fields_t      live;
        cal_fields_t      shadow;
        logic             run;
        logic             snap;
        logic             view;
        logic [EVTS-1:0]  evt;
    } cal_state_t;

    // one BCD step up, valid for 00..98
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(bcd8_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import bcd_cal_pkg::*;
(
    input  bcd8_t month,
    input  bcd8_t year,
    output bcd8_t last_day
);
    logic [6:0] year_bin;
    logic       leap;

    assign year_bin = bcd_to_bin(year);
    assign leap     = (year_bin[1:0] == 2'b00);

    always_comb begin
        case (month)
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import bcd_cal_pkg::*;
#(
    parameter bcd8_t SEC_TOP  = 8'h59,
    parameter bcd8_t HOUR_TOP = 8'h23,
    parameter bcd8_t WDAY_TOP = 8'h06,
    parameter bcd8_t MON_TOP  = 8'h12,
    parameter bcd8_t YEAR_TOP = 8'h99
) (
    input  cal_fields_t cur,
    input  bcd8_t       last_day,
    output cal_fields_t nxt,
    output logic        wrap_sec,
    output logic        wrap_min,
    output logic        wrap_hour
);
    logic wrap_day, wrap_mon;

    always_comb begin
        wrap_sec  = cur[IX_SEC]  >= SEC_TOP;
        wrap_min  = wrap_sec  && (cur[IX_MIN]  >= SEC_TOP);
        wrap_hour = wrap_min  && (cur[IX_HOUR] >= HOUR_TOP);
        wrap_day  = wrap_hour && (cur[IX_DAY]  >= last_day);
        wrap_mon  = wrap_day  && (cur[IX_MON]  >= MON_TOP);

        nxt = cur;
        nxt[IX_SEC] = wrap_sec ? 8'h00 : bcd_inc(cur[IX_SEC]);
        if (wrap_sec)
            nxt[IX_MIN] = wrap_min ? 8'h00 : bcd_inc(cur[IX_MIN]);
        if (wrap_min)
            nxt[IX_HOUR] = wrap_hour ? 8'h00 : bcd_inc(cur[IX_HOUR]);
        if (wrap_hour) begin
            nxt[IX_DAY]  = wrap_day ? 8'h01 : bcd_inc(cur[IX_DAY]);
            nxt[IX_WDAY] = (cur[IX_WDAY] >= WDAY_TOP) ? 8'h00 : bcd_inc(cur[IX_WDAY]);
        end
        if (wrap_day)
            nxt[IX_MON] = wrap_mon ? 8'h01 : bcd_inc(cur[IX_MON]);
        if (wrap_mon)
            nxt[IX_YEAR] = (cur[IX_YEAR] >= YEAR_TOP) ? 8'h00 : bcd_inc(cur[IX_YEAR]);
    end
endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  cal_fields_t       live,
    input  cal_fields_t       shadow,
    input  logic              view,
    input  logic [7:0]        ctrl_byte,
    output logic [7:0]        rd_data
);
    cal_fields_t sel;

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_field
            assign sel[g] = view ? shadow[g] : live[g];
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        if (addr < ADDR_W'(FIELDS))
            rd_data = sel[addr[2:0]];
        else if (addr == ADDR_W'(CTRL_ADDR))
            rd_data = ctrl_byte;
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              evt_sec,
    output logic              evt_min,
    output logic              evt_hour,
    output logic              evt_day
);
    localparam int RUN_BIT  = 0;
    localparam int SNAP_BIT = 6;
    localparam int VIEW_BIT = 7;

    cal_state_t  s_q, s_d;
    cal_fields_t adv_next;
    bcd8_t       last_day;
    logic        w_sec, w_min, w_hour;
    logic        time_wr, ctrl_wr;
    logic [7:0]  ctrl_byte;

    assign time_wr = wr_en && (reg_addr < ADDR_W'(FIELDS));
    assign ctrl_wr = wr_en && (reg_addr == ADDR_W'(CTRL_ADDR));

    cal_month_len u_len (
        .month    (s_q.live[IX_MON]),
        .year     (s_q.live[IX_YEAR]),
        .last_day (last_day)
    );

    cal_advance u_adv (
        .cur       (s_q.live),
        .last_day  (last_day),
        .nxt       (adv_next),
        .wrap_sec  (w_sec),
        .wrap_min  (w_min),
        .wrap_hour (w_hour)
    );

    always_comb begin
        ctrl_byte           = 8'h00;
        ctrl_byte[RUN_BIT]  = s_q.run;
        ctrl_byte[SNAP_BIT] = s_q.snap;
        ctrl_byte[VIEW_BIT] = s_q.view;
    end

    cal_read_mux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_rd (
        .addr      (reg_addr),
        .live      (s_q.live),
        .shadow    (s_q.shadow),
        .view      (s_q.view),
        .ctrl_byte (ctrl_byte),
        .rd_data   (rd_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.evt  = '0;
        s_d.snap = 1'b0;

        // pending snapshot: freeze all live fields in one cycle
        if (s_q.snap) begin
            s_d.shadow = s_q.live;
            s_d.view   = 1'b1;
        end

        // host write beats the tick; the tick is dropped
        if (time_wr) begin
            s_d.live[reg_addr[2:0]] = wr_data;
        end else if (tick_1hz && s_q.run) begin
            s_d.live = adv_next;
            s_d.evt  = {w_hour, w_min, w_sec, 1'b1};
        end

        if (ctrl_wr) begin
            s_d.run  = wr_data[RUN_BIT];
            s_d.snap = wr_data[SNAP_BIT];
            if (!wr_data[SNAP_BIT])
                s_d.view = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q               <= '0;
            s_q.live[IX_DAY]  <= 8'h01;
            s_q.live[IX_MON]  <= 8'h01;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt_sec  = s_q.evt[0];
    assign evt_min  = s_q.evt[1];
    assign evt_hour = s_q.evt[2];
    assign evt_day  = s_q.evt[3];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       run,
    input logic       time_wr,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [3:0] evt
);
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr) |=> $stable(sec));

    assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !evt[0]);

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |-> (sec == 8'h00));

    assert_min_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |-> (min == 8'h00));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> !evt[0]);

    assert_chain_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |-> evt[0]);

    assert_chain_hour_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |-> evt[1]);

    assert_chain_day_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[3] |-> evt[2]);
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .run     (s_q.run),
    .time_wr (time_wr),
    .sec     (s_q.live[0]),
    .min     (s_q.live[1]),
    .evt     (s_q.evt)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CTRL_A = 4'h8;
    localparam int NV = 14;

    // {start sec,min,hour,day,mon,year,wday ; expected same order ; events day,hour,min,sec}
    localparam logic [115:0] VEC [NV] = '{
        {56'h00000001010000, 56'h01000001010000, 4'h1},  // R2
        {56'h09090910101001, 56'h10090910101001, 4'h1},  // R2 ones digit 9
        {56'h59341215062303, 56'h00351215062303, 4'h3},  // R3
        {56'h59591215062303, 56'h00001315062303, 4'h7},  // R3
        {56'h59592315062303, 56'h00000016062304, 4'hF},  // R3 R6
        {56'h59592330042306, 56'h00000001052300, 4'hF},  // R4 R6 30-day month
        {56'h59592330052301, 56'h00000031052302, 4'hF},  // R4 31-day month
        {56'h59592331012306, 56'h00000001022300, 4'hF},  // R4
        {56'h59592331129902, 56'h00000001010003, 4'hF},  // R4 year wrap
        {56'h59592328022401, 56'h00000029022402, 4'hF},  // R5 leap
        {56'h59592328022301, 56'h00000001032302, 4'hF},  // R5 common
        {56'h59592329020005, 56'h00000001030006, 4'hF},  // R5 year 00
        {56'h59592328021004, 56'h00000001031005, 4'hF},  // R5 year 10
        {56'h59592328021204, 56'h00000029021205, 4'hF}   // R5 year 12
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       evt_sec, evt_min, evt_hour, evt_day;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar u_bcd_calendar (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick_1hz),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .evt_sec  (evt_sec),
        .evt_min  (evt_min),
        .evt_hour (evt_hour),
        .evt_day  (evt_day)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_all(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(4'(i), b);
            t[55-8*i -: 8] = b;
        end
    endtask

    task automatic set_time(input logic [55:0] t);
        wr(CTRL_A, 8'h00);
        for (int i = 0; i < 7; i++) wr(4'(i), t[55-8*i -: 8]);
    endtask

    // one tick; returns the events seen in the cycle after the edge
    task automatic do_tick(output logic [3:0] ev);
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        ev = {evt_day, evt_hour, evt_min, evt_sec};
    endtask

    initial begin
        logic [55:0] t;
        logic [7:0]  b;
        logic [3:0]  ev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_all(t);
        chk("R1 time after reset", 64'(t), 64'h00000001010000);
        rd(CTRL_A, b);
        chk("R1 control after reset", 64'(b), 64'h00);
        chk("R1 events after reset", 64'({evt_day, evt_hour, evt_min, evt_sec}), 64'h0);

        // vector walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            set_time(VEC[i][115:60]);
            wr(CTRL_A, 8'h01);
            do_tick(ev);
            chk($sformatf("R9 events vector %0d", i), 64'(ev), 64'(VEC[i][3:0]));
            @(negedge clk);
            chk($sformatf("R9 pulse width vector %0d", i),
                64'({evt_day, evt_hour, evt_min, evt_sec}), 64'h0);
            rd_all(t);
            chk($sformatf("R4 R5 R6 time vector %0d", i), 64'(t), 64'(VEC[i][59:4]));
        end

        // R2 halted counter ignores ticks
        set_time(56'h05000001010000);
        do_tick(ev);
        chk("R2 no event while halted", 64'(ev), 64'h0);
        rd(4'h0, b);
        chk("R2 seconds held while halted", 64'(b), 64'h05);

        // R10 verbatim store, reserved control bits read 0
        wr(4'h6, 8'h04);
        rd(4'h6, b);
        chk("R10 weekday readback", 64'(b), 64'h04);
        wr(CTRL_A, 8'h2B);
        rd(CTRL_A, b);
        chk("R10 reserved control bits", 64'(b), 64'h01);

        // R8 write on a tick cycle wins, tick dropped
        @(negedge clk);
        tick_1hz = 1'b1;
        wr_en    = 1'b1;
        reg_addr = 4'h1;
        wr_data  = 8'h10;
        @(negedge clk);
        tick_1hz = 1'b0;
        wr_en    = 1'b0;
        chk("R8 no event on write cycle", 64'(evt_sec), 64'h0);
        rd(4'h0, b);
        chk("R8 seconds not advanced", 64'(b), 64'h05);
        rd(4'h1, b);
        chk("R8 written minutes", 64'(b), 64'h10);

        // R7 snapshot
        set_time(56'h30201005050500);
        wr(CTRL_A, 8'h41);
        rd(CTRL_A, b);
        chk("R7 snapshot bit visible", 64'(b), 64'h41);
        @(negedge clk);
        rd(CTRL_A, b);
        chk("R7 snapshot self-clears, view set", 64'(b), 64'h81);
        for (int k = 0; k < 3; k++) do_tick(ev);
        @(negedge clk);
        rd(4'h0, b);
        chk("R7 shadow seconds frozen", 64'(b), 64'h30);
        rd_all(t);
        chk("R7 shadow fields", 64'(t), 64'h30201005050500);
        wr(CTRL_A, 8'h01);
        rd(4'h0, b);
        chk("R7 live seconds after view cleared", 64'(b), 64'h33);
        rd(CTRL_A, b);
        chk("R7 control after clear", 64'(b), 64'h01);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule